// File: doc/BRIEF.md
# SPI Slave Register-Access Bridge

This block lets an external SPI master read and write a small on-chip register file that belongs to a serial-port controller. Each frame starts when chip select goes low. The first byte received is a command. Its top bit picks read (1) or write (0). The next four bits name one of sixteen registers. Two bits after that pick a channel. The lowest bit is ignored. Every byte after the command, for as long as chip select stays low, touches the same register. A data-port register can therefore be filled or drained as a burst of 64 bytes or more in a single frame.

All pins are brought into the fast system clock through a synchronizer. The block works on the rising and falling serial-clock edges it sees there. Register accesses appear on a simple internal bus as a one-cycle strobe. The strobe comes with a direction, an address, a channel and write data, and read data is returned on a separate input. The serial clock must stay high for at least 4 system clocks and low for at least 4 system clocks. A 5 MHz serial clock therefore needs a system clock of 40 MHz or more.

Top module: `spi_regbridge`

## Requirements
- R1: Bits are shifted in MSB first on rising serial-clock edges. In the command byte, bit 7 is the direction (1 = read, 0 = write), bits 6:3 are the register address, bits 2:1 are the channel, and bit 0 has no effect.
- R2: In a frame with a write command, each completed data byte produces exactly one single-cycle `reg_req` with `reg_wr`=1. The command's address and channel come with it, and `reg_wdata` equals the byte.
- R3: The address does not auto-increment. Every data byte of a frame, including a burst of 64 bytes, accesses the register named by the command.
- R4: A read command issues one `reg_req` with `reg_wr`=0 when the command byte completes. `reg_rdata` is captured in the cycle after the strobe and shifted out on `spi_miso` MSB first, one bit per falling serial-clock edge, starting with the fall after the command's last rising edge. Each completed data byte then issues the next read, which supplies the following byte.
- R5: A channel code other than 00 produces no `reg_req` during that frame, and `spi_miso` stays 0.
- R6: Raising chip select before a byte is complete discards that byte without any access, and the next frame starts with a command byte.
- R7: `spi_miso` is 0 while chip select is high and during write frames.
- R8: Counted from the system-clock edge that first samples a serial-clock rising edge, any strobe it causes is visible after the second following edge. A `spi_miso` change follows a sampled falling edge with the same delay.
- R9: After reset, `reg_req` and `spi_miso` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from the master |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |
| reg_req | output | 1 | One-cycle register access strobe |
| reg_wr | output | 1 | Access direction, 1 = write |
| reg_addr | output | 4 | Register address |
| reg_chan | output | 2 | Channel code |
| reg_wdata | output | 8 | Write data |
| reg_rdata | input | 8 | Read data, sampled the cycle after a read strobe |

## Verification
Every input edge reaches the design logic two system-clock edges after it is first sampled. A strobe or a `spi_miso` change therefore becomes visible after that second edge, and read data is loaded one edge after its strobe. The bench keeps its own delayed record of the pins it drove and steps a behavioural frame model on each rising clock edge. It then compares strobe, direction, address, channel, write data and `spi_miso` at the following falling edge, so each expected value is checked in the cycle it falls due. On top of that, each frame is checked for its count of strobes and for the bytes the master received.

// File: rtl/spi_regbridge_pkg.sv
// Shared types and constants for the SPI register bridge.
// Assumes a one-byte command followed by byte-wide data.
package spi_regbridge_pkg;

    localparam int unsigned BYTE_W  = 8;
    localparam int unsigned REG_AW  = 4;
    localparam int unsigned CHAN_W  = 2;
    localparam int unsigned BCNT_W  = $clog2(BYTE_W);

    localparam logic [CHAN_W-1:0] CHAN_VALID = '0;

    typedef struct packed {
        logic              rd;
        logic [REG_AW-1:0] addr;
        logic [CHAN_W-1:0] chan;
    } spi_cmd_t;

    // Split the seven meaningful command bits (bit 0 is dropped by the caller).
    function automatic spi_cmd_t decode_cmd(input logic [BYTE_W-1:1] b);
        spi_cmd_t c;
        c.rd   = b[BYTE_W-1];
        c.addr = b[BYTE_W-2 -: REG_AW];
        c.chan = b[CHAN_W:1];
        return c;
    endfunction

endpackage

// File: rtl/spi_in_sync.sv
// Multi-flop synchronizer for a small group of asynchronous pins.
// Assumes STAGES >= 2; each bit is synchronized on its own.
module spi_in_sync #(
    parameter int unsigned        W       = 3,
    parameter int unsigned        STAGES  = 2,
    parameter logic [W-1:0]       RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg;

    // Shift the pin values through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) stg <= {STAGES{RST_VAL}};
        else        stg <= {stg[STAGES-2:0], d};
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_sclk_edge.sv
// Finds rising and falling edges of the synchronized serial clock.
// Assumes the input is already in the clk domain.
module spi_sclk_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_s,
    output logic rise,
    output logic fall
);
    logic prev;

    // Remember last cycle's serial clock level.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= sclk_s;
    end

    assign rise = sclk_s & ~prev;
    assign fall = ~sclk_s & prev;
endmodule

// File: rtl/spi_frame_ctrl.sv
// Receives bits, decodes the command byte and issues register strobes.
// Assumes rise pulses are at least two cycles apart and cs_act is synchronized.
module spi_frame_ctrl
    import spi_regbridge_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_act,
    input  logic              rise,
    input  logic              mosi_s,
    output logic              req,
    output logic              wr,
    output logic [REG_AW-1:0] addr,
    output logic [CHAN_W-1:0] chan,
    output logic [BYTE_W-1:0] wdata
);
    logic [BCNT_W-1:0] bit_cnt;
    logic [BYTE_W-2:0] shreg;
    logic              have_cmd;
    spi_cmd_t          cmd;
    spi_cmd_t          dec;
    logic [BYTE_W-1:0] byte_now;
    logic              byte_done;
    logic              cmd_ok;

    assign byte_now  = {shreg, mosi_s};
    assign byte_done = rise && (bit_cnt == BCNT_W'(BYTE_W-1));
    assign dec       = decode_cmd(byte_now[BYTE_W-1:1]);
    assign cmd_ok    = (cmd.chan == CHAN_VALID);

    // Bit counting, shifting, command capture and strobe generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            shreg    <= '0;
            have_cmd <= 1'b0;
            cmd      <= '0;
            req      <= 1'b0;
            wdata    <= '0;
        end else begin
            req <= 1'b0;
            if (!cs_act) begin
                bit_cnt  <= '0;
                have_cmd <= 1'b0;
            end else if (rise) begin
                bit_cnt <= bit_cnt + 1'b1;
                shreg   <= byte_now[BYTE_W-2:0];
                if (byte_done) begin
                    if (!have_cmd) begin
                        have_cmd <= 1'b1;
                        cmd      <= dec;
                        req      <= dec.rd && (dec.chan == CHAN_VALID);
                    end else if (cmd_ok) begin
                        req <= 1'b1;
                        if (!cmd.rd) wdata <= byte_now;
                    end
                end
            end
        end
    end

    assign wr   = ~cmd.rd;
    assign addr = cmd.addr;
    assign chan = cmd.chan;
endmodule

// File: rtl/spi_tx_shifter.sv
// Holds read data and drives it out MSB first on falling serial-clock edges.
// Assumes a load never lands in the same cycle as a fall.
module spi_tx_shifter
    import spi_regbridge_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_act,
    input  logic              fall,
    input  logic              load,
    input  logic [BYTE_W-1:0] load_data,
    output logic              miso
);
    logic [BYTE_W-1:0] tx_sr;

    // Clear when deselected, else load read data or shift out one bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sr <= '0;
            miso  <= 1'b0;
        end else if (!cs_act) begin
            tx_sr <= '0;
            miso  <= 1'b0;
        end else if (load) begin
            tx_sr <= load_data;
        end else if (fall) begin
            miso  <= tx_sr[BYTE_W-1];
            tx_sr <= {tx_sr[BYTE_W-2:0], 1'b0};
        end
    end
endmodule

// File: rtl/spi_regbridge.sv
// Top of the SPI slave bridge to the internal register bus.
// Assumes serial-clock phases of at least 4 clk periods each.
module spi_regbridge
    import spi_regbridge_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sclk,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic              reg_req,
    output logic              reg_wr,
    output logic [REG_AW-1:0] reg_addr,
    output logic [CHAN_W-1:0] reg_chan,
    output logic [BYTE_W-1:0] reg_wdata,
    input  logic [BYTE_W-1:0] reg_rdata
);
    localparam int unsigned PINS = 3;

    logic [PINS-1:0] pins_s;
    logic sclk_s, cs_n_s, mosi_s;
    logic cs_act, sclk_rise, sclk_fall;

    spi_in_sync #(.W(PINS), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({spi_sclk, spi_cs_n, spi_mosi}),
        .q     (pins_s)
    );

    assign {sclk_s, cs_n_s, mosi_s} = pins_s;
    assign cs_act = ~cs_n_s;

    spi_sclk_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sclk_s (sclk_s),
        .rise   (sclk_rise),
        .fall   (sclk_fall)
    );

    spi_frame_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .cs_act (cs_act),
        .rise   (sclk_rise),
        .mosi_s (mosi_s),
        .req    (reg_req),
        .wr     (reg_wr),
        .addr   (reg_addr),
        .chan   (reg_chan),
        .wdata  (reg_wdata)
    );

    spi_tx_shifter u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_act    (cs_act),
        .fall      (sclk_fall),
        .load      (reg_req & ~reg_wr),
        .load_data (reg_rdata),
        .miso      (spi_miso)
    );
endmodule

// File: rtl/spi_regbridge_chk.sv
// Property checker for the SPI register bridge, bound to the top module.
// Assumes access to the synchronized chip select and the rise pulse.
module spi_regbridge_chk
    import spi_regbridge_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              reg_req,
    input logic [CHAN_W-1:0] reg_chan,
    input logic              spi_miso,
    input logic              cs_act,
    input logic              sclk_rise
);
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        reg_req |=> !reg_req);

    a_r5_valid_channel: assert property (@(posedge clk) disable iff (!rst_n)
        reg_req |-> reg_chan == CHAN_VALID);

    a_r7_quiet_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> !spi_miso);

    a_r8_strobe_from_rise: assert property (@(posedge clk) disable iff (!rst_n)
        reg_req |-> $past(sclk_rise));

    a_r6_strobe_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        reg_req |-> $past(cs_act));
endmodule

bind spi_regbridge spi_regbridge_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_req   (reg_req),
    .reg_chan  (reg_chan),
    .spi_miso  (spi_miso),
    .cs_act    (cs_act),
    .sclk_rise (sclk_rise)
);

// File: tb/spi_regbridge_test.sv
// Bench: SPI master tasks, a register-file responder and a per-clock model.
module spi_regbridge_test;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 5;
    localparam int WDOG       = 150000;

    logic clk = 0, rst_n = 0, sclk = 0, cs_n = 1, mosi = 0;
    logic miso, reg_req, reg_wr;
    logic [3:0] reg_addr;
    logic [1:0] reg_chan;
    logic [7:0] reg_wdata, reg_rdata;
    int rdcnt = 0;
    int checks = 0, fails = 0;
    int n_req = 0, n_wr = 0;
    string phase = "reset";

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_regbridge uut (
        .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n),
        .spi_mosi(mosi), .spi_miso(miso), .reg_req(reg_req), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_chan(reg_chan), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata)
    );

    function automatic logic [7:0] rd_val(input logic [3:0] a, input int c);
        return {a, 4'h0} ^ c[7:0] ^ 8'h5A;
    endfunction

    // Register-file responder: each read strobe pops the next value.
    assign reg_rdata = rd_val(reg_addr, rdcnt);
    always @(posedge clk) if (rst_n && reg_req && !reg_wr) rdcnt <= rdcnt + 1;

    // Behavioural reference model, stepped on every rising clock edge.
    logic h_s[4], h_c[4], h_m[4];
    int   m_cnt, m_rdc;
    logic [7:0] m_sh, m_tx, e_wdata;
    logic m_have, m_rd, pend, e_miso, e_req, e_wr;
    logic [3:0] m_addr;
    logic [1:0] m_chan;

    always @(posedge clk) begin
        logic cs_on, rs, fl, ld;
        for (int i = 3; i > 0; i--) begin
            h_s[i] = h_s[i-1]; h_c[i] = h_c[i-1]; h_m[i] = h_m[i-1];
        end
        h_s[0] = sclk; h_c[0] = cs_n; h_m[0] = mosi;
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) begin h_s[i] = 0; h_c[i] = 1; h_m[i] = 0; end
            m_cnt = 0; m_rdc = 0; m_sh = 0; m_tx = 0; m_have = 0; m_rd = 0;
            pend = 0; e_miso = 0; e_req = 0; e_wr = 0; e_wdata = 0;
            m_addr = 0; m_chan = 0;
        end else begin
            cs_on = !h_c[2];
            rs = h_s[2] && !h_s[3];
            fl = !h_s[2] && h_s[3];
            ld = 0;
            e_req = 0;
            if (pend) begin
                if (cs_on) begin m_tx = rd_val(m_addr, m_rdc); ld = 1; end
                m_rdc++;
                pend = 0;
            end
            if (!cs_on) begin
                m_cnt = 0; m_have = 0; e_miso = 0; m_tx = 0;
            end else begin
                if (!ld && fl) begin e_miso = m_tx[7]; m_tx = {m_tx[6:0], 1'b0}; end
                if (rs) begin
                    m_sh = {m_sh[6:0], h_m[2]};
                    if (m_cnt == 7) begin
                        m_cnt = 0;
                        if (!m_have) begin
                            m_have = 1; m_rd = m_sh[7]; m_addr = m_sh[6:3]; m_chan = m_sh[2:1];
                            if (m_rd && m_chan == 2'b00) begin e_req = 1; e_wr = 0; pend = 1; end
                        end else if (m_chan == 2'b00) begin
                            e_req = 1; e_wr = !m_rd;
                            if (!m_rd) e_wdata = m_sh; else pend = 1;
                        end
                    end else m_cnt++;
                end
            end
        end
    end

    // Per-clock comparison against the model (R8 timing, with phase tag).
    always @(negedge clk) if (rst_n) begin
        checks++;
        if (reg_req !== e_req || miso !== e_miso ||
            (e_req && (reg_wr !== e_wr || reg_addr !== m_addr || reg_chan !== m_chan ||
                       (e_wr && reg_wdata !== e_wdata)))) begin
            fails++;
            $display("FAIL R8/%s t=%0t: req=%0b wr=%0b addr=%0h chan=%0h wd=%0h miso=%0b exp req=%0b wr=%0b addr=%0h chan=%0h wd=%0h miso=%0b",
                phase, $time, reg_req, reg_wr, reg_addr, reg_chan, reg_wdata, miso,
                e_req, e_wr, m_addr, m_chan, e_wdata, e_miso);
        end
        if (reg_req) begin n_req++; if (reg_wr) n_wr++; end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic frame_start();
        @(negedge clk); cs_n = 0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic frame_end();
        @(negedge clk); sclk = 0;
        repeat (HALF) @(negedge clk);
        cs_n = 1;
        repeat (2*HALF) @(negedge clk);
    endtask

    task automatic send_bits(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
        rx = 0;
        for (int i = 7; i > 7 - nbits; i--) begin
            @(negedge clk); sclk = 0; mosi = tx[i];
            repeat (HALF) @(negedge clk);
            rx[i] = miso; sclk = 1;
            repeat (HALF-1) @(negedge clk);
        end
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        send_bits(tx, 8, rx);
    endtask

    initial begin
        repeat (WDOG) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual %0d cycles expected finish", WDOG);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] rx;
        int r0, w0, c0;
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R9 reset state
        check(reg_req === 1'b0, "R9 reg_req after reset", reg_req, 0);
        check(miso === 1'b0, "R9 miso after reset", miso, 0);

        // R2 single write to register 5
        phase = "R2 write"; w0 = n_wr;
        frame_start(); xfer(8'h28, rx); xfer(8'hC3, rx); frame_end();
        check(n_wr - w0 == 1, "R2 write strobes", n_wr - w0, 1);

        // R1 command bit 0 set has no effect
        phase = "R1 bit0"; w0 = n_wr;
        frame_start(); xfer(8'h29, rx); xfer(8'h3C, rx); frame_end();
        check(n_wr - w0 == 1, "R1 bit0 ignored strobes", n_wr - w0, 1);

        // R3 64-byte burst to register 0
        phase = "R3 burst"; w0 = n_wr;
        frame_start(); xfer(8'h00, rx);
        for (int i = 0; i < 64; i++) xfer(8'(i*3+1), rx);
        frame_end();
        check(n_wr - w0 == 64, "R3 burst strobes", n_wr - w0, 64);

        // R4 single read of register 9
        phase = "R4 read"; r0 = n_req; c0 = rdcnt;
        frame_start(); xfer(8'hC8, rx); xfer(8'h00, rx); frame_end();
        check(rx == rd_val(4'd9, c0), "R4 read byte", rx, rd_val(4'd9, c0));
        check(n_req - r0 == 2, "R4 read strobes", n_req - r0, 2);

        // R4 and R3 read burst of three bytes from register 0
        phase = "R4 burst"; c0 = rdcnt;
        frame_start(); xfer(8'h80, rx);
        for (int i = 0; i < 3; i++) begin
            xfer(8'hFF, rx);
            check(rx == rd_val(4'd0, c0 + i), "R4 burst byte", rx, rd_val(4'd0, c0 + i));
        end
        frame_end();

        // R5 reserved channel codes
        phase = "R5 chan"; r0 = n_req;
        frame_start(); xfer(8'h2A, rx); xfer(8'h11, rx); frame_end();
        frame_start(); xfer(8'hCE, rx); xfer(8'h00, rx); frame_end();
        check(n_req - r0 == 0, "R5 reserved channel strobes", n_req - r0, 0);
        check(rx == 8'h00, "R5 miso on reserved read", rx, 0);

        // R6 abort mid command, then a full frame; abort mid data byte
        phase = "R6 abort"; w0 = n_wr;
        frame_start(); send_bits(8'h28, 4, rx); frame_end();
        frame_start(); xfer(8'h10, rx); xfer(8'h77, rx); frame_end();
        check(n_wr - w0 == 1, "R6 frame after aborted command", n_wr - w0, 1);
        w0 = n_wr;
        frame_start(); xfer(8'h18, rx); send_bits(8'hA5, 5, rx); frame_end();
        check(n_wr - w0 == 0, "R6 aborted data byte", n_wr - w0, 0);

        // R7 miso idle and on write frames
        phase = "R7 idle";
        check(miso === 1'b0, "R7 miso while deselected", miso, 0);
        frame_start(); xfer(8'h28, rx); xfer(8'hFF, rx);
        check(rx == 8'h00, "R7 miso during write frame", rx, 0);
        frame_end();

        repeat (4) @(negedge clk);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule